// File: doc/BRIEF.md
# Multi-Epoch Annealing Sequencer

This block steers a simulated-annealing search over a pair of binary vectors (a row vector and a column vector). The energy of each candidate pair comes from an outside evaluator: the sequencer raises a request that carries the candidate, and the evaluator answers with a one-cycle valid pulse and a signed energy. From each answer the sequencer decides whether to take the candidate. It keeps the lowest-energy pair seen so far and counts the answers that land too close to the current energy. It then flips a few pseudo-random bits to make the next candidate.

The search runs as a series of epochs. An epoch has no fixed length. It ends when the count of near-equal answers reaches a programmed limit. The next epoch restarts from the best pair found so far, and its temperature returns to the programmed start value. After a programmed number of epochs the sequencer stops, raises `done` and shows the best pair and its energy.

Top module: `anneal_seq`

## Requirements
- R1: `req` stays high with `cand_h`/`cand_v` stable until the cycle in which `e_valid` is sampled high. `req` is then low for exactly one cycle. Each new candidate is presented when `req` rises again.
- R2: The first request after `start` carries `seed_h`/`seed_v` unchanged. Its energy becomes both the current energy and the best energy, with no decision taken on it.
- R3: An answer below the current energy by more than `tol` is always taken. Taking it clears the near-equal count. The best pair and `best_e` update when the answer is below `best_e`, and the new values show one cycle after the valid pulse. Taking an answer above the current energy never changes the best.
- R4: An answer with |e_new − current| ≤ `tol` leaves the current pair and energy unchanged and adds one to the near-equal count.
- R5: An answer above the current energy by more than `tol` is taken when a free-running 16-bit nonzero LFSR sample is ≤ the temperature. A temperature of 0 therefore never takes it, and 16'hFFFF always does.
- R6: After every decision the temperature drops by `temp_step`, with a floor of 0. It reloads `temp_init` at the start of every epoch.
- R7: Each candidate after the first equals the current pair, concatenated as {xh, xv}, with between 1 and NFLIP bits inverted (default NFLIP = 2). An index drawn twice flips once.
- R8: When the near-equal count reaches `trap_max`, the epoch ends. The next epoch takes the best pair and `best_e` as its current state without evaluating them again, and its first candidate lies within NFLIP bits of the best pair.
- R9: After `epoch_max` epochs have ended, `done` goes high and stays high, `req` stays low, and the best pair and `best_e` are held until the next `start`.
- R10: During and right after reset, `req`, `busy` and `done` are low.
- R11: Energies are two's-complement. Every ordering and tolerance test is signed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle or done) |
| seed_h | input | XH_W | Initial row vector |
| seed_v | input | XV_W | Initial column vector |
| temp_init | input | 16 | Temperature at each epoch start |
| temp_step | input | 16 | Temperature drop per decision |
| tol | input | E_W | Near-equal tolerance (unsigned) |
| trap_max | input | CNT_W | Near-equal count that ends an epoch |
| epoch_max | input | EP_W | Number of epochs in a run |
| req | output | 1 | Energy request, candidate valid |
| cand_h | output | XH_W | Candidate row vector |
| cand_v | output | XV_W | Candidate column vector |
| e_valid | input | 1 | Energy answer pulse |
| e_new | input | E_W | Signed energy of the candidate |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| best_h | output | XH_W | Best row vector |
| best_v | output | XV_W | Best column vector |
| best_e | output | E_W | Signed best energy |

## Verification
A decision lands on the clock edge that samples `e_valid`. `best_e`, `best_h` and `best_v` are therefore due one cycle after the pulse, and the bench reads them at the next falling edge, once the pulse has been withdrawn. The next candidate is due with the next rise of `req` two edges later, so the bench records candidates only at falling edges where `req` is high. The end of an epoch and of the run are judged by counting requests until `done` is seen at a falling edge. Each stimulus pattern gives a different count depending on acceptance, trap clearing, temperature decay and epoch restart.

// File: rtl/anneal_seq.sv
module anneal_seq #(
  parameter int XH_W  = 8,
  parameter int XV_W  = 8,
  parameter int E_W   = 16,
  parameter int CNT_W = 12,
  parameter int EP_W  = 8,
  parameter int NFLIP = 2,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [XH_W-1:0]       seed_h,
  input  logic [XV_W-1:0]       seed_v,
  input  logic [15:0]           temp_init,
  input  logic [15:0]           temp_step,
  input  logic [E_W-1:0]        tol,
  input  logic [CNT_W-1:0]      trap_max,
  input  logic [EP_W-1:0]       epoch_max,
  output logic                  req,
  output logic [XH_W-1:0]       cand_h,
  output logic [XV_W-1:0]       cand_v,
  input  logic                  e_valid,
  input  logic signed [E_W-1:0] e_new,
  output logic                  busy,
  output logic                  done,
  output logic [XH_W-1:0]       best_h,
  output logic [XV_W-1:0]       best_v,
  output logic signed [E_W-1:0] best_e
);
  localparam int NB = XH_W + XV_W;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam int LW = 16;

  typedef enum logic [1:0] {S_IDLE, S_ASK, S_GAP, S_FIN} st_t;

  st_t                  st;
  logic [LW-1:0]        lfsr;
  logic [NB-1:0]        cand_x, cur_x, best_x, flip_mask, new_cur;
  logic signed [E_W-1:0] e_o;
  logic [15:0]          temp, temp_dec;
  logic [CNT_W-1:0]     trap, trap_inc;
  logic [EP_W-1:0]      epoch;
  logic                 first;
  logic [E_W:0]         diff, mag;
  logic                 near, down, up_ok, take, better, epoch_end, last_epoch, decide;

  assign cand_h = cand_x[NB-1:XV_W];
  assign cand_v = cand_x[XV_W-1:0];
  assign best_h = best_x[NB-1:XV_W];
  assign best_v = best_x[XV_W-1:0];
  assign req    = (st == S_ASK);
  assign busy   = (st == S_ASK) || (st == S_GAP);
  assign done   = (st == S_FIN);

  assign diff       = {e_new[E_W-1], e_new} - {e_o[E_W-1], e_o};
  assign mag        = diff[E_W] ? -diff : diff;
  assign near       = mag <= {1'b0, tol};
  assign down       = diff[E_W] && !near;
  assign up_ok      = lfsr <= temp;
  assign take       = !near && (down || up_ok);
  assign better     = take && (e_new < best_e);
  assign trap_inc   = trap + 1'b1;
  assign epoch_end  = near && (trap_inc >= trap_max);
  assign last_epoch = ({1'b0, epoch} + 1'b1) >= {1'b0, epoch_max};
  assign temp_dec   = (temp > temp_step) ? temp - temp_step : 16'd0;
  assign new_cur    = take ? cand_x : cur_x;
  assign decide     = (st == S_ASK) && e_valid && !first;

  always_comb begin
    logic [2*LW-1:0] lf2;
    logic [IW-1:0]   chunk;
    logic [IW-1:0]   idx;
    lf2 = {lfsr, lfsr};
    flip_mask = '0;
    for (int k = 0; k < NFLIP; k++) begin
      chunk = IW'(lf2 >> ((k * IW) % LW));
      idx   = IW'(32'(chunk) % NB);
      flip_mask[idx] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lfsr   <= LFSR_SEED;
      cand_x <= '0;
      cur_x  <= '0;
      best_x <= '0;
      e_o    <= '0;
      best_e <= '0;
      temp   <= '0;
      trap   <= '0;
      epoch  <= '0;
      first  <= 1'b0;
    end else begin
      lfsr <= {1'b0, lfsr[LW-1:1]} ^ (lfsr[0] ? 16'hB400 : 16'h0000);
      case (st)
        S_IDLE, S_FIN: if (start) begin
          cand_x <= {seed_h, seed_v};
          first  <= 1'b1;
          epoch  <= '0;
          trap   <= '0;
          temp   <= temp_init;
          st     <= S_ASK;
        end
        S_ASK: if (e_valid) begin
          st <= S_GAP;
          if (first) begin
            first  <= 1'b0;
            cur_x  <= cand_x;
            best_x <= cand_x;
            e_o    <= e_new;
            best_e <= e_new;
            cand_x <= cand_x ^ flip_mask;
          end else if (epoch_end) begin
            trap  <= '0;
            temp  <= temp_init;
            epoch <= epoch + 1'b1;
            if (last_epoch) begin
              st <= S_FIN;
            end else begin
              cur_x  <= best_x;
              e_o    <= best_e;
              cand_x <= best_x ^ flip_mask;
            end
          end else begin
            cur_x  <= new_cur;
            if (take) e_o <= e_new;
            if (near)      trap <= trap_inc;
            else if (down) trap <= '0;
            temp   <= temp_dec;
            if (better) begin
              best_x <= cand_x;
              best_e <= e_new;
            end
            cand_x <= new_cur ^ flip_mask;
          end
        end
        S_GAP: st <= S_ASK;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_cand_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !e_valid) |=> (req && $stable(cand_x)));

  assert_req_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req && e_valid) |=> !req);

  assert_best_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    decide |=> (best_e <= $past(best_e)));

  assert_temp_falls_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !epoch_end) |=> (temp <= $past(temp)));

  assert_flip_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (decide && !epoch_end) |=> (($countones(cand_x ^ cur_x) >= 1) &&
                                ($countones(cand_x ^ cur_x) <= NFLIP)));

  assert_trap_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && trap_max != '0) |-> (trap < trap_max));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && !req && $stable(best_e) && $stable(best_x)));

endmodule

// File: tb/anneal_seq_test.sv
`timescale 1ns/1ps
module anneal_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] seed_h = 8'h00, seed_v = 8'h00;
  logic [15:0] temp_init = 16'd0, temp_step = 16'd0;
  logic [15:0] tol = 16'd0;
  logic [11:0] trap_max = 12'd3;
  logic [7:0] epoch_max = 8'd1;
  logic req, busy, done;
  logic [7:0] cand_h, cand_v, best_h, best_v;
  logic e_valid = 1'b0;
  logic signed [15:0] e_new = 16'sd0;
  logic signed [15:0] best_e;

  always #2.5 clk = ~clk;

  anneal_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .seed_h(seed_h), .seed_v(seed_v),
    .temp_init(temp_init), .temp_step(temp_step), .tol(tol), .trap_max(trap_max),
    .epoch_max(epoch_max), .req(req), .cand_h(cand_h), .cand_v(cand_v),
    .e_valid(e_valid), .e_new(e_new), .busy(busy), .done(done),
    .best_h(best_h), .best_v(best_v), .best_e(best_e));

  localparam int NTAB = 10;
  localparam logic signed [15:0] TAB_E [NTAB] = '{16'sd50, 16'sd80, 16'sd20, -16'sd5, 16'sd30,
                                                  -16'sd40, -16'sd3, -16'sd41, 16'sd100, -16'sd100};
  localparam logic signed [15:0] TAB_B [NTAB] = '{16'sd50, 16'sd50, 16'sd20, -16'sd5, -16'sd5,
                                                  -16'sd40, -16'sd40, -16'sd41, -16'sd41, -16'sd100};

  int total = 0, bad = 0;
  logic signed [15:0] resp [16];
  int nresp;
  logic signed [15:0] tail;
  logic [15:0] hist [64];
  int nreq;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hd(input logic [15:0] a, input logic [15:0] b);
    return $countones(a ^ b);
  endfunction

  task automatic go(input logic [15:0] ti, input logic [15:0] ts, input logic [15:0] tl,
                    input logic [11:0] tm, input logic [7:0] em);
    temp_init = ti; temp_step = ts; tol = tl; trap_max = tm; epoch_max = em;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    nreq = 0;
  endtask

  task automatic serve();
    int cyc;
    cyc = 0;
    while (!done && cyc < 4000) begin
      if (req) begin
        hist[nreq % 64] = {cand_h, cand_v};
        e_new = (nreq < nresp) ? resp[nreq] : tail;
        e_valid = 1'b1;
        @(negedge clk); e_valid = 1'b0;
        nreq++;
      end else begin
        @(negedge clk);
      end
      cyc++;
    end
    if (!done) chk(1'b0, "R9 run did not finish", nreq, -1);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] seed, cur;
    logic signed [15:0] cur_e;
    logic [15:0] best_exp;
    int gaps;
    seed_h = 8'hA5; seed_v = 8'h3C;
    seed = {8'hA5, 8'h3C};
    repeat (3) @(negedge clk);
    chk(!req && !busy && !done, "R10 reset outputs", {req, busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req && !busy && !done, "R10 idle after reset", {req, busy, done}, 0);

    // table walk: T = 0, tol = 0, signed energies
    go(16'd0, 16'd0, 16'd0, 12'd3, 8'd1);
    cur = seed; cur_e = 0; best_exp = seed;
    for (int i = 0; i < NTAB; i++) begin
      logic [15:0] c;
      while (!req) @(negedge clk);
      c = {cand_h, cand_v};
      if (i == 0) chk(c == seed, "R2 first candidate is seed", c, seed);
      else chk(hd(c, cur) >= 1 && hd(c, cur) <= 2, "R7 flip distance", hd(c, cur), 2);
      e_new = TAB_E[i]; e_valid = 1'b1;
      @(negedge clk); e_valid = 1'b0;
      chk(!req, "R1 req low after answer", req, 0);
      if (i == 0 || TAB_E[i] < cur_e) begin
        cur = c; cur_e = TAB_E[i];
      end
      if (TAB_B[i] == TAB_E[i]) best_exp = c;
      chk(best_e == TAB_B[i], "R3 R11 best energy", best_e, TAB_B[i]);
      chk({best_h, best_v} == best_exp, "R3 best vectors", {best_h, best_v}, best_exp);
    end
    nreq = NTAB; nresp = 0; tail = -16'sd100;
    serve();
    chk(nreq == NTAB + 3, "R4 R9 tail traps end run", nreq, NTAB + 3);
    chk(best_e == -16'sd100, "R11 final best", best_e, -100);
    gaps = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (req || !done || best_e != -16'sd100) gaps++;
    end
    chk(gaps == 0, "R9 done holds quietly", gaps, 0);

    // tolerance: every answer within 5 of 100 is a trap
    resp[0] = 100; resp[1] = 103; resp[2] = 97; resp[3] = 105; resp[4] = 95;
    nresp = 5; tail = 100;
    go(16'd0, 16'd0, 16'd5, 12'd4, 8'd1);
    serve();
    chk(nreq == 5, "R4 near answers count as traps", nreq, 5);
    chk(best_e == 16'sd100, "R4 best unchanged", best_e, 100);
    chk({best_h, best_v} == seed, "R4 best vectors stay seed", {best_h, best_v}, seed);

    // trap clear on a real improvement
    resp[0] = 100; resp[1] = 100; resp[2] = 90;
    nresp = 3; tail = 90;
    go(16'd0, 16'd0, 16'd0, 12'd3, 8'd1);
    serve();
    chk(nreq == 6, "R3 improvement clears trap count", nreq, 6);

    // uphill always taken at full temperature
    resp[0] = 10; resp[1] = 20; resp[2] = 30; resp[3] = 40;
    nresp = 4; tail = 40;
    go(16'hFFFF, 16'd0, 16'd0, 12'd3, 8'd1);
    serve();
    chk(nreq == 7, "R5 uphill taken at T max", nreq, 7);
    for (int i = 2; i <= 4; i++)
      chk(hd(hist[i], hist[i-1]) >= 1 && hd(hist[i], hist[i-1]) <= 2,
          "R5 R7 next candidate from accepted one", hd(hist[i], hist[i-1]), 2);
    chk(best_e == 16'sd10, "R3 uphill never improves best", best_e, 10);

    // uphill never taken at zero temperature
    resp[0] = 10; resp[1] = 20; resp[2] = 20; resp[3] = 20;
    nresp = 4; tail = 10;
    go(16'd0, 16'd0, 16'd0, 12'd3, 8'd1);
    serve();
    chk(nreq == 7, "R5 uphill refused at T zero", nreq, 7);
    for (int i = 1; i < 7; i++)
      chk(hd(hist[i], seed) >= 1 && hd(hist[i], seed) <= 2,
          "R7 candidates stay near seed", hd(hist[i], seed), 2);

    // temperature falls to its floor after one decision
    resp[0] = 10; resp[1] = 20; resp[2] = 30;
    nresp = 3; tail = 20;
    go(16'hFFFF, 16'hFFFF, 16'd0, 12'd3, 8'd1);
    serve();
    chk(nreq == 6, "R6 temperature decrement with floor", nreq, 6);

    // two epochs: restart from best, temperature reloaded
    resp[0] = 100; resp[1] = 200; resp[2] = 200; resp[3] = 200; resp[4] = 300;
    nresp = 5; tail = 300;
    go(16'hFFFF, 16'hFFFF, 16'd0, 12'd2, 8'd2);
    serve();
    chk(nreq == 7, "R6 R8 second epoch with reloaded temperature", nreq, 7);
    chk(hd(hist[4], seed) >= 1 && hd(hist[4], seed) <= 2,
        "R8 new epoch starts from best", hd(hist[4], seed), 2);
    chk(best_e == 16'sd100 && {best_h, best_v} == seed, "R8 R9 best kept across epochs", best_e, 100);
    chk(done && !req, "R9 done after epoch count", {done, req}, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule